// File: doc/BRIEF.md
# Sliding-Window Aperture Decoder

This block sits on the device side of a small host-visible memory aperture and turns each host access into either an access to the large internal 32-bit address space or a local read of configuration data. The aperture is cut into four fixed regions. Three of them are translation windows (called A, C and B here). Each window adds its own programmable base to the offset of the access inside the window. The fourth region is a read-only copy of a block of configuration registers, which the configuration space feeds in as a flat vector.

The host presents an aperture byte offset, a size code, a direction and write data. One clock edge later the block either issues a request on the internal memory port, or answers the host itself. It answers itself for mirror-region accesses and for malformed accesses. Answers from internal memory are forwarded to the host in the same cycle they arrive. All three window bases are loaded through a separate configuration write port. Software moves window B across internal memory by rewriting its base, and the block keeps that base aligned to the window B size.

Top module: `win_aperture_dec`

## Requirements
- R1: Offsets 0x00 through 0x57 select window A, and the internal address is the A base plus the offset.
- R2: Offsets 0x58 through 0x5F select window C, and the internal address is the C base plus (offset minus 0x58).
- R3: A read at offsets 0x60 through 0x7F issues no memory request. One edge after the request it answers with rsp_valid high, rsp_err low and the mirror dword whose index is bits [4:2] of (offset minus 0x60). Dword k is cfg_mirror[32k+31:32k].
- R4: A write at offsets 0x60 through 0x7F is dropped. It issues no memory request and gets a response with rsp_err low and data zero.
- R5: Offsets from 0x80 up to 0x80 + 2^SWB_BITS - 1 select window B, and the internal address is the B base plus (offset minus 0x80).
- R6: A configuration write with cfg_wr_sel = 1 loads the B base, with its low SWB_BITS bits forced to zero.
- R7: cfg_wr_sel = 0 loads the A base and cfg_wr_sel = 2 loads the C base with the full 32-bit value. cfg_wr_sel = 3 loads nothing.
- R8: The size code req_size is 0 for a byte, 1 for 16 bits and 2 for 32 bits. mem_be is the size mask 0001, 0011 or 1111 shifted left by offset[1:0]. mem_wdata equals req_wdata and mem_write equals req_write.
- R9: The block answers with rsp_err high and issues no memory request in each of these cases: the access does not fit in one aligned 32-bit word, its first and last bytes lie in different regions, it reaches past the aperture end, or its size code is 3.
- R10: After reset all three window bases are zero, and mem_req and rsp_valid are low.
- R11: While mem_rvalid is high, rsp_valid is high and rsp_rdata equals mem_rdata in the same cycle.
- R12: mem_req is a one-cycle pulse on the edge after the accepted request. A base written on one edge applies to a request presented on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Size code: 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| req_offset | input | OFFS_W | Aperture byte offset |
| req_wdata | input | 32 | Write data, already placed on the byte lanes |
| rsp_valid | output | 1 | Response strobe to the host |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Response read data |
| cfg_wr_en | input | 1 | Configuration base write strobe |
| cfg_wr_sel | input | 2 | Base select: 0 A, 1 B, 2 C, 3 none |
| cfg_wr_data | input | 32 | Base value |
| cfg_mirror | input | 256 | Configuration register copy, dword k at bits [32k+31:32k] |
| mem_req | output | 1 | Internal memory request pulse |
| mem_write | output | 1 | Internal request direction |
| mem_addr | output | 32 | Internal byte address |
| mem_be | output | 4 | Internal byte enables |
| mem_wdata | output | 32 | Internal write data |
| mem_rvalid | input | 1 | Internal memory completion |
| mem_rdata | input | 32 | Internal memory read data |

## Verification
The decoded request appears on the memory port one clock edge after the host strobe. The local answer for mirror and error accesses also arrives one edge later. A completion from internal memory reaches the host response with no delay. A base value written on one edge is used by the very next request. Each scenario task drives its inputs on a falling edge and samples the registered results at the next falling edge, so exactly one rising edge lies in between. Memory completions are driven on a falling edge and checked a short delay later in the same cycle.

// File: rtl/winap_pkg.sv
package winap_pkg;
  typedef enum logic [1:0] {
    RG_A   = 2'd0,
    RG_C   = 2'd1,
    RG_MIR = 2'd2,
    RG_B   = 2'd3
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] BSEL_A = 2'd0;
  localparam logic [1:0] BSEL_B = 2'd1;
  localparam logic [1:0] BSEL_C = 2'd2;

  localparam int MIR_WORDS = 8;
  localparam int C_START   = 'h58;
  localparam int MIR_START = 'h60;
  localparam int B_START   = 'h80;
endpackage

// File: rtl/aperture_region_dec.sv
module aperture_region_dec
  import winap_pkg::*;
#(
  parameter int OFFS_W   = 9,
  parameter int APER_END = 'h180
) (
  input  logic [OFFS_W-1:0] offset,
  input  logic [1:0]        size,
  output region_e           region,
  output logic [OFFS_W-1:0] local_offs,
  output logic [3:0]        be,
  output logic              err
);
  localparam logic [OFFS_W-1:0] OFS_C   = OFFS_W'(C_START);
  localparam logic [OFFS_W-1:0] OFS_MIR = OFFS_W'(MIR_START);
  localparam logic [OFFS_W-1:0] OFS_B   = OFFS_W'(B_START);
  localparam logic [OFFS_W:0]   END_X   = (OFFS_W+1)'(APER_END);

  function automatic region_e classify(input logic [OFFS_W-1:0] v);
    if (v < OFS_C)        return RG_A;
    else if (v < OFS_MIR) return RG_C;
    else if (v < OFS_B)   return RG_MIR;
    else                  return RG_B;
  endfunction

  logic [2:0]      nbytes;
  logic [3:0]      mask;
  logic            bad_size;
  logic [OFFS_W:0] last_ofs;
  logic [2:0]      lane_sum;
  region_e         region_last;

  always_comb begin
    bad_size = 1'b0;
    case (size)
      SZ_BYTE: begin nbytes = 3'd1; mask = 4'b0001; end
      SZ_HALF: begin nbytes = 3'd2; mask = 4'b0011; end
      SZ_WORD: begin nbytes = 3'd4; mask = 4'b1111; end
      default: begin nbytes = 3'd1; mask = 4'b0000; bad_size = 1'b1; end
    endcase
    last_ofs    = {1'b0, offset} + (OFFS_W+1)'(nbytes) - (OFFS_W+1)'(1);
    lane_sum    = {1'b0, offset[1:0]} + nbytes;
    region      = classify(offset);
    region_last = classify(last_ofs[OFFS_W-1:0]);
    be          = mask << offset[1:0];
    err         = bad_size || (lane_sum > 3'd4) || (last_ofs >= END_X)
                  || (region_last != region);
    case (region)
      RG_A:    local_offs = offset;
      RG_C:    local_offs = offset - OFS_C;
      RG_MIR:  local_offs = offset - OFS_MIR;
      default: local_offs = offset - OFS_B;
    endcase
  end
endmodule

// File: rtl/window_base_regs.sv
module window_base_regs
  import winap_pkg::*;
#(
  parameter int SWB_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [1:0]  cfg_wr_sel,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] a_base,
  output logic [31:0] b_base,
  output logic [31:0] c_base
);
  localparam logic [31:0] B_KEEP = ~((32'd1 << SWB_BITS) - 32'd1);

  logic a_en, b_en, c_en;
  logic [31:0] b_next;

  always_comb begin
    a_en   = cfg_wr_en && (cfg_wr_sel == BSEL_A);
    b_en   = cfg_wr_en && (cfg_wr_sel == BSEL_B);
    c_en   = cfg_wr_en && (cfg_wr_sel == BSEL_C);
    b_next = cfg_wr_data & B_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_base <= '0;
      b_base <= '0;
      c_base <= '0;
    end else begin
      if (a_en) a_base <= cfg_wr_data;
      if (b_en) b_base <= b_next;
      if (c_en) c_base <= cfg_wr_data;
    end
  end
endmodule

// File: rtl/win_aperture_dec.sv
module win_aperture_dec
  import winap_pkg::*;
#(
  parameter int SWB_BITS = 8,
  parameter int OFFS_W   = SWB_BITS + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [OFFS_W-1:0]      req_offset,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata,
  input  logic                   cfg_wr_en,
  input  logic [1:0]             cfg_wr_sel,
  input  logic [31:0]            cfg_wr_data,
  input  logic [32*MIR_WORDS-1:0] cfg_mirror,
  output logic                   mem_req,
  output logic                   mem_write,
  output logic [31:0]            mem_addr,
  output logic [3:0]             mem_be,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_rvalid,
  input  logic [31:0]            mem_rdata
);
  localparam int APER_END = B_START + (1 << SWB_BITS);

  logic [31:0] a_base_w, b_base_w, c_base_w;
  region_e     dec_region;
  logic [OFFS_W-1:0] dec_local;
  logic [3:0]  dec_be;
  logic        dec_err;

  window_base_regs #(.SWB_BITS(SWB_BITS)) u_bases (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_sel, .cfg_wr_data,
    .a_base(a_base_w), .b_base(b_base_w), .c_base(c_base_w)
  );

  aperture_region_dec #(.OFFS_W(OFFS_W), .APER_END(APER_END)) u_dec (
    .offset(req_offset), .size(req_size), .region(dec_region),
    .local_offs(dec_local), .be(dec_be), .err(dec_err)
  );

  logic [31:0] mir_word [MIR_WORDS];
  for (genvar k = 0; k < MIR_WORDS; k++) begin : g_mir
    assign mir_word[k] = cfg_mirror[32*k +: 32];
  end

  logic        mem_req_d, loc_vld_d;
  logic [31:0] sel_base, addr_d, loc_data_d;
  logic        is_mir;

  always_comb begin
    is_mir = (dec_region == RG_MIR);
    case (dec_region)
      RG_A:    sel_base = a_base_w;
      RG_C:    sel_base = c_base_w;
      default: sel_base = b_base_w;
    endcase
    addr_d     = sel_base + 32'(dec_local);
    mem_req_d  = req_valid && !dec_err && !is_mir;
    loc_vld_d  = req_valid && (dec_err || is_mir);
    loc_data_d = (is_mir && !dec_err && !req_write) ? mir_word[dec_local[4:2]] : '0;
  end

  logic        loc_vld_q, loc_err_q;
  logic [31:0] loc_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      loc_vld_q <= 1'b0;
    end else begin
      mem_req   <= mem_req_d;
      loc_vld_q <= loc_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      loc_err_q  <= 1'b0;
      loc_data_q <= '0;
    end else if (req_valid) begin
      mem_write  <= req_write;
      mem_addr   <= addr_d;
      mem_be     <= dec_be;
      mem_wdata  <= req_wdata;
      loc_err_q  <= dec_err;
      loc_data_q <= loc_data_d;
    end
  end

  always_comb begin
    rsp_valid = loc_vld_q || mem_rvalid;
    rsp_err   = loc_vld_q && loc_err_q;
    rsp_rdata = loc_vld_q ? loc_data_q : mem_rdata;
  end
endmodule

// File: rtl/winap_checker.sv
module winap_checker #(
  parameter int SWB_BITS = 8,
  parameter int OFFS_W   = SWB_BITS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_size,
  input logic [OFFS_W-1:0] req_offset,
  input logic              mem_req,
  input logic [31:0]       mem_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       a_base,
  input logic [31:0]       b_base,
  input logic [31:0]       c_base
);
  localparam int APER_END = 'h80 + (1 << SWB_BITS);

  assert_a_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0 && req_offset < OFFS_W'('h58))
    |=> (mem_req && mem_addr == $past(a_base) + 32'($past(req_offset))));

  assert_mirror_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0 && req_offset >= OFFS_W'('h60)
     && req_offset < OFFS_W'('h80))
    |=> (rsp_valid && !rsp_err && !mem_req));

  assert_b_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_base[SWB_BITS-1:0] == '0);

  assert_range_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_offset) >= APER_END)
    |=> (rsp_valid && rsp_err && !mem_req));

  assert_reset_bases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a_base == '0 && b_base == '0 && c_base == '0));
endmodule

bind win_aperture_dec winap_checker #(.SWB_BITS(SWB_BITS), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .req_offset(req_offset), .mem_req(mem_req), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .a_base(a_base_w), .b_base(b_base_w), .c_base(c_base_w)
);

// File: tb/win_aperture_dec_test.sv
module win_aperture_dec_test;
  localparam int SWB_BITS = 8;
  localparam int OFFS_W   = SWB_BITS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [OFFS_W-1:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = 2'd3;
  logic [31:0] cfg_wr_data = '0;
  logic [255:0] cfg_mirror;
  logic mem_req, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_aperture_dec #(.SWB_BITS(SWB_BITS)) uut (.*);

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [OFFS_W-1:0] ofs, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = ofs; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_sel = 2'd3;
  endtask

  task automatic mem_answer(input logic [31:0] d);
    mem_rvalid = 1'b1; mem_rdata = d;
    #1;
    check("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    check("R11 rsp_rdata", rsp_rdata, d);
    @(negedge clk);
    mem_rvalid = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 mem_req after reset", 32'(mem_req), 32'd0);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    access(1'b0, 2'd0, 9'h010, '0);
    check("R10 A base zero", mem_addr, 32'h0000_0010);
    access(1'b0, 2'd0, 9'h080, '0);
    check("R10 B base zero", mem_addr, 32'h0000_0000);
    access(1'b0, 2'd0, 9'h05A, '0);
    check("R10 C base zero", mem_addr, 32'h0000_0002);
  endtask

  task automatic t_cfg;
    cfg_write(2'd0, 32'h1000_0000);
    cfg_write(2'd2, 32'h2000_0000);
    cfg_write(2'd1, 32'h3000_12FF);
    cfg_write(2'd3, 32'hDEAD_BEEF);
    access(1'b0, 2'd0, 9'h081, '0);
    check("R6 B base aligned", mem_addr, 32'h3000_1201);
    access(1'b0, 2'd0, 9'h000, '0);
    check("R7 A base load", mem_addr, 32'h1000_0000);
    access(1'b0, 2'd0, 9'h058, '0);
    check("R7 C base load, sel 3 no effect", mem_addr, 32'h2000_0000);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 2'd0; cfg_wr_data = 32'h4400_0000;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_sel = 2'd3;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_offset = 9'h004;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 base used by next request", mem_addr, 32'h4400_0004);
    check("R12 mem_req pulse high", 32'(mem_req), 32'd1);
    @(negedge clk);
    check("R12 mem_req pulse ends", 32'(mem_req), 32'd0);
    cfg_write(2'd0, 32'h1000_0000);
  endtask

  task automatic t_windows;
    access(1'b0, 2'd2, 9'h054, '0);
    check("R1 addr", mem_addr, 32'h1000_0054);
    check("R1 mem_req", 32'(mem_req), 32'd1);
    check("R8 word be", 32'(mem_be), 32'hF);
    mem_answer(32'hCAFE_F00D);
    access(1'b1, 2'd0, 9'h05D, 32'h0000_AB00);
    check("R2 addr", mem_addr, 32'h2000_0005);
    check("R8 byte be lane1", 32'(mem_be), 32'b0010);
    check("R8 write flag", 32'(mem_write), 32'd1);
    check("R8 wdata", mem_wdata, 32'h0000_AB00);
    mem_answer(32'h0);
    access(1'b0, 2'd1, 9'h17E, '0);
    check("R5 addr top of B", mem_addr, 32'h3000_12FE);
    check("R8 half be upper", 32'(mem_be), 32'b1100);
    access(1'b0, 2'd1, 9'h080, '0);
    check("R5 addr B start", mem_addr, 32'h3000_1200);
    check("R8 half be lower", 32'(mem_be), 32'b0011);
  endtask

  task automatic t_mirror;
    access(1'b0, 2'd2, 9'h06C, '0);
    check("R3 mirror valid", 32'(rsp_valid), 32'd1);
    check("R3 no mem_req", 32'(mem_req), 32'd0);
    check("R3 word 3", rsp_rdata, 32'hC0DE_0003);
    access(1'b0, 2'd0, 9'h07D, '0);
    check("R3 word 7", rsp_rdata, 32'hC0DE_0007);
    check("R3 no error", 32'(rsp_err), 32'd0);
    access(1'b1, 2'd2, 9'h064, 32'h1234_5678);
    check("R4 write answered", 32'(rsp_valid), 32'd1);
    check("R4 write no mem_req", 32'(mem_req), 32'd0);
    check("R4 write no error", 32'(rsp_err), 32'd0);
    check("R4 write data zero", rsp_rdata, 32'h0);
    access(1'b0, 2'd2, 9'h064, '0);
    check("R4 mirror unchanged", rsp_rdata, 32'hC0DE_0001);
  endtask

  task automatic t_errors;
    access(1'b0, 2'd1, 9'h057, '0);
    check("R9 lane cross err", 32'(rsp_err), 32'd1);
    check("R9 lane cross no mem_req", 32'(mem_req), 32'd0);
    access(1'b0, 2'd2, 9'h05E, '0);
    check("R9 region cross err", 32'(rsp_err), 32'd1);
    access(1'b0, 2'd0, 9'h180, '0);
    check("R9 past end err", 32'(rsp_err), 32'd1);
    check("R9 past end no mem_req", 32'(mem_req), 32'd0);
    access(1'b0, 2'd3, 9'h010, '0);
    check("R9 bad size err", 32'(rsp_err), 32'd1);
    check("R9 bad size valid", 32'(rsp_valid), 32'd1);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) cfg_mirror[32*k +: 32] = 32'hC0DE_0000 + 32'(k);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_windows();
    t_mirror();
    t_errors();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule